// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides conditional branches while the branch instruction sits in the decode/register-read stage of a five-stage pipeline. It needs only a zero test on one source register, not a full comparator. A dedicated adder in the same stage computes the taken target from the incremented PC and the sign-extended word offset. A taken branch therefore redirects fetch in the same cycle it is decoded, so at most one fetched instruction is wasted.

The block drives the select of the next-PC multiplexer, the redirect address, and a flush for the instruction currently in the fetch stage. A parameter picks the control-hazard policy:
- **Squash mode.** Fetch continues sequentially from PC+4. On a taken branch, the one wrongly fetched successor is turned into a no-op by clearing its IF/ID valid bit.
- **Delay-slot mode.** The successor always runs, and control moves to the target afterwards.

When fetch is stalled by another source, a redirect is parked in a one-entry hold register and released in the first stall-free cycle.

Top module: `branch_resolve_unit`

## Requirements
- R1: With `dec_kind` = 1 (branch-if-zero) and `dec_valid` high, a redirect is requested exactly when every bit of `dec_src` is zero.
- R2: With `dec_kind` = 2 (branch-if-nonzero) and `dec_valid` high, a redirect is requested exactly when at least one bit of `dec_src` is set.
- R3: `dec_kind` = 3 (jump) always requests a redirect. `dec_kind` = 0 (no branch) never does, and nothing is requested while `dec_valid` is low.
- R4: `redirect_pc` equals `dec_pc_inc` plus the 16-bit `dec_offset` sign-extended and shifted left by two, with wrap-around modulo 2^32. Negative offsets point backwards.
- R5: The decision is combinational in the decode cycle. With no stall, `pc_sel_target` rises in the same cycle the branch is presented, which costs one cycle of penalty.
- R6: With `SQUASH_MODE` = 1, `fetch_flush` is asserted in exactly the cycles `pc_sel_target` is asserted.
- R7: With `SQUASH_MODE` = 0 (delay slot), `fetch_flush` stays low and `pc_sel_target` behaves as in squash mode.
- R8: While `fetch_stall` is high, `pc_sel_target` and `fetch_flush` stay low. A redirect requested during a stall is held, together with the target computed at that time, and is issued for exactly one cycle in the first cycle `fetch_stall` is low. Decode inputs are ignored while a redirect is held.
- R9: Synchronous reset discards a held redirect, so no redirect appears after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode-stage instruction valid |
| dec_kind | input | 2 | Branch kind: 0 none, 1 if-zero, 2 if-nonzero, 3 jump |
| dec_src | input | 32 | Source register value under test |
| dec_pc_inc | input | 32 | PC+4 of the branch |
| dec_offset | input | 16 | Signed word offset |
| fetch_stall | input | 1 | Fetch held by another source |
| pc_sel_target | output | 1 | Next-PC multiplexer picks `redirect_pc` |
| redirect_pc | output | 32 | Taken-branch target |
| fetch_flush | output | 1 | Clear valid bit of instruction in IF/ID |

## Verification
The zero test is tried with:
- an all-zero register;
- a small nonzero value;
- a value with only the sign bit set, which separates a true all-bits test from a sign or low-bit test.

Each of these is paired with both conditional kinds, plus jump and no-branch. The target adder is tried with positive offsets, an offset of minus one, and the most negative offset, which exposes a missing sign extension or a missing shift. Two instances, one per mode, get identical stimulus, so a flush difference points at the mode parameter alone. Stall sequences change the decode inputs while a redirect is parked. A released redirect that carries the old target and lasts one cycle shows that the hold register captures the target and clears itself.

// File: rtl/br_pkg.sv
package br_pkg;
    parameter int ADDR_W = 32;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_EQZ  = 2'd1,
        BK_NEZ  = 2'd2,
        BK_JMP  = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic              take;
        logic [ADDR_W-1:0] tgt;
    } redirect_s;

    function automatic logic kind_taken(br_kind_e k, logic src_zero);
        case (k)
            BK_EQZ:  return src_zero;
            BK_NEZ:  return !src_zero;
            BK_JMP:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/br_zero_test.sv
module br_zero_test #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    output logic         is_zero
);
    assign is_zero = (val == '0);
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] pc_inc,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W - 2;

    logic [ADDR_W-1:0] byte_off;

    assign byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    assign target   = pc_inc + byte_off;
endmodule

// File: rtl/br_redirect_hold.sv
module br_redirect_hold
    import br_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  redirect_s live,
    input  logic      stall,
    output redirect_s issued,
    output logic      held
);
    logic              hold_q;
    logic [ADDR_W-1:0] hold_tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            hold_tgt_q <= '0;
        end else if (hold_q) begin
            if (!stall) hold_q <= 1'b0;
        end else if (live.take && stall) begin
            hold_q     <= 1'b1;
            hold_tgt_q <= live.tgt;
        end
    end

    always_comb begin
        if (hold_q) begin
            issued.take = !stall;
            issued.tgt  = hold_tgt_q;
        end else begin
            issued.take = live.take && !stall;
            issued.tgt  = live.tgt;
        end
    end

    assign held = hold_q;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import br_pkg::*;
#(
    parameter int OFF_W       = 16,
    parameter bit SQUASH_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [1:0]        dec_kind,
    input  logic [ADDR_W-1:0] dec_src,
    input  logic [ADDR_W-1:0] dec_pc_inc,
    input  logic [OFF_W-1:0]  dec_offset,
    input  logic              fetch_stall,
    output logic              pc_sel_target,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              fetch_flush
);
    logic      src_zero;
    logic      held;
    redirect_s live;
    redirect_s issued;

    br_zero_test #(.W(ADDR_W)) u_zero (
        .val     (dec_src),
        .is_zero (src_zero)
    );

    br_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
        .pc_inc (dec_pc_inc),
        .offset (dec_offset),
        .target (live.tgt)
    );

    assign live.take = dec_valid && kind_taken(br_kind_e'(dec_kind), src_zero);

    br_redirect_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .live   (live),
        .stall  (fetch_stall),
        .issued (issued),
        .held   (held)
    );

    assign pc_sel_target = issued.take;
    assign redirect_pc   = issued.tgt;

    generate
        if (SQUASH_MODE) begin : g_squash
            assign fetch_flush = issued.take;
        end else begin : g_delay
            assign fetch_flush = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk
    import br_pkg::*;
#(
    parameter bit SQUASH_MODE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              dec_valid,
    input logic [1:0]        dec_kind,
    input logic [ADDR_W-1:0] dec_src,
    input logic              fetch_stall,
    input logic              pc_sel_target,
    input logic              fetch_flush,
    input logic              held
);
    AST_FLUSH_WITH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        fetch_flush |-> pc_sel_target); // R6

    AST_SQUASH_FLUSH_MATCH: assert property (@(posedge clk) disable iff (rst)
        (SQUASH_MODE && pc_sel_target) |-> fetch_flush); // R6

    AST_DELAY_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !SQUASH_MODE |-> !fetch_flush); // R7

    AST_QUIET_IN_STALL: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> (!pc_sel_target && !fetch_flush)); // R8

    AST_HOLD_PERSISTS: assert property (@(posedge clk) disable iff (rst)
        (held && fetch_stall) |=> held); // R8

    AST_HOLD_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (held && !fetch_stall) |-> pc_sel_target); // R8

    AST_EQZ_ZERO_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!held && !fetch_stall && dec_valid && dec_kind == 2'd1 && dec_src == '0)
        |-> pc_sel_target); // R1

    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!held && (dec_kind == 2'd0 || !dec_valid)) |-> !pc_sel_target); // R3
endmodule

bind branch_resolve_unit branch_resolve_chk #(.SQUASH_MODE(SQUASH_MODE)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dec_valid     (dec_valid),
    .dec_kind      (dec_kind),
    .dec_src       (dec_src),
    .fetch_stall   (fetch_stall),
    .pc_sel_target (pc_sel_target),
    .fetch_flush   (fetch_flush),
    .held          (held)
);

// File: tb/branch_resolve_unit_test.sv
module branch_resolve_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        dec_valid;
    logic [1:0]  dec_kind;
    logic [31:0] dec_src;
    logic [31:0] dec_pc_inc;
    logic [15:0] dec_offset;
    logic        fetch_stall;
    logic        sel_s, sel_d, fl_s, fl_d;
    logic [31:0] tgt_s, tgt_d;
    int          total = 0;
    int          bad   = 0;

    always #10 clk = ~clk;

    branch_resolve_unit #(.SQUASH_MODE(1'b1)) uut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_src(dec_src), .dec_pc_inc(dec_pc_inc), .dec_offset(dec_offset),
        .fetch_stall(fetch_stall), .pc_sel_target(sel_s),
        .redirect_pc(tgt_s), .fetch_flush(fl_s));

    branch_resolve_unit #(.SQUASH_MODE(1'b0)) uut_dly (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_src(dec_src), .dec_pc_inc(dec_pc_inc), .dec_offset(dec_offset),
        .fetch_stall(fetch_stall), .pc_sel_target(sel_d),
        .redirect_pc(tgt_d), .fetch_flush(fl_d));

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] src;
        logic [31:0] pc4;
        logic [15:0] off;
        logic        take;
        logic [31:0] tgt;
    } vec_s;

    localparam int NV = 8;
    localparam vec_s VECS [NV] = '{
        '{2'd1, 32'h0000_0000, 32'h0000_0104, 16'h0003, 1'b1, 32'h0000_0110}, // R1 R4
        '{2'd1, 32'h0000_0005, 32'h0000_0104, 16'h0003, 1'b0, 32'h0000_0110}, // R1
        '{2'd1, 32'h8000_0000, 32'h0000_0104, 16'h0003, 1'b0, 32'h0000_0110}, // R1
        '{2'd2, 32'h0000_0005, 32'h0000_0200, 16'hFFFF, 1'b1, 32'h0000_01FC}, // R2 R4
        '{2'd2, 32'h8000_0000, 32'h0000_0040, 16'h0010, 1'b1, 32'h0000_0080}, // R2
        '{2'd2, 32'h0000_0000, 32'h0000_0200, 16'hFFFF, 1'b0, 32'h0000_01FC}, // R2
        '{2'd3, 32'h0000_0007, 32'h0000_1000, 16'h8000, 1'b1, 32'hFFFE_1000}, // R3 R4
        '{2'd0, 32'h0000_0000, 32'h0000_0104, 16'h0003, 1'b0, 32'h0000_0110}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [31:0] s,
                         input logic [31:0] p, input logic [15:0] o, input logic st);
        dec_valid = v; dec_kind = k; dec_src = s;
        dec_pc_inc = p; dec_offset = o; fetch_stall = st;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 2'd0, '0, '0, '0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset sel", {31'd0, sel_s}, 32'd0);
        check("R9 reset flush", {31'd0, fl_s}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VECS[i].kind, VECS[i].src, VECS[i].pc4, VECS[i].off, 1'b0);
            #2;
            check("R1/R2/R3 R5 take squash", {31'd0, sel_s}, {31'd0, VECS[i].take});
            check("R7 take delay", {31'd0, sel_d}, {31'd0, VECS[i].take});
            check("R6 flush squash", {31'd0, fl_s}, {31'd0, VECS[i].take});
            check("R7 flush delay", {31'd0, fl_d}, 32'd0);
            if (VECS[i].take) begin
                check("R4 target", tgt_s, VECS[i].tgt);
                check("R4 target delay", tgt_d, VECS[i].tgt);
            end
        end

        // R3: invalid decode slot never redirects
        @(negedge clk);
        drive(1'b0, 2'd3, 32'd0, 32'h104, 16'd3, 1'b0);
        #2;
        check("R3 invalid", {31'd0, sel_s}, 32'd0);

        // R8: stall hold and release
        @(negedge clk);
        drive(1'b1, 2'd1, 32'd0, 32'h0000_0104, 16'h0003, 1'b1);
        #2;
        check("R8 quiet in stall", {30'd0, sel_s, fl_s}, 32'd0);
        @(negedge clk);
        drive(1'b1, 2'd2, 32'd0, 32'h0000_0900, 16'h0001, 1'b1);
        #2;
        check("R8 still quiet", {30'd0, sel_s, fl_s}, 32'd0);
        @(negedge clk);
        fetch_stall = 1'b0;
        #2;
        check("R8 release sel", {31'd0, sel_s}, 32'd1);
        check("R8 release flush", {31'd0, fl_s}, 32'd1);
        check("R8 held target", tgt_s, 32'h0000_0110);
        check("R8 delay no flush", {31'd0, fl_d}, 32'd0);
        @(negedge clk);
        #2;
        check("R8 single cycle", {31'd0, sel_s}, 32'd0);

        // R9: reset discards held redirect
        @(negedge clk);
        drive(1'b1, 2'd3, 32'd1, 32'h0000_0300, 16'h0002, 1'b1);
        @(negedge clk);
        drive(1'b0, 2'd0, 32'd0, 32'd0, 16'd0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        fetch_stall = 1'b0;
        #2;
        check("R9 held discarded", {31'd0, sel_s}, 32'd0);
        check("R9 held discarded delay", {31'd0, sel_d}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule